// File: doc/BRIEF.md
# Interval Timer Host Register Interface

This block sits between a byte-wide processor bus and three independent down-counting timer channels. The host writes a configuration byte to a shared control port. That byte selects a channel and sets the channel's operating mode, its number format (binary or BCD) and the order in which the bytes of the 16-bit count are transferred. Count bytes written to a channel's own port are then assembled into a 16-bit reload value in that order. Each finished value is handed to the channel's counting logic with a one-cycle strobe.

Each channel has its own read path. The host can read the channel's live count as bytes, in the same order that the channel's writes use, and reads keep a byte toggle separate from the one used for writes. For each channel the block also presents the effective divisor. This is the reload value, except that a reload of zero stands for the largest divisor of the selected number format. The counting logic, count latching and status reporting live elsewhere.

Top module: `tmr_host_if`

## Requirements
- R1: Addresses 0, 1 and 2 select the count ports of channels 0, 1 and 2, and address 3 selects the control port. A count write raises only that channel's `ch_load` bit, for exactly the one cycle after the write edge.
- R2: A control byte carries fields that are decoded as follows:
  - bit 0 is the BCD flag (1 = BCD);
  - bits 3..1 are the mode;
  - bits 5..4 are the access order;
  - bits 7..6 are the target channel.
  Channel, mode and format take effect on the clock edge that samples the write, and the target's `ch_cfg_wr` bit pulses for one cycle. For example, byte 0x54 gives channel 1, mode 2, binary format and low-byte-only access.
- R3: Mode codes 6 and 7 are stored as modes 2 and 3, so `ch_mode` never shows a value above 5.
- R4: A control byte is ignored entirely if its access field is 00 or its target field is 11. Mode, format, access order and both byte toggles stay as they were, and no strobe pulses.
- R5: With access order 01 (low only), each count write produces reload = {8'h00, byte} and a `ch_load` pulse.
- R6: With access order 10 (high only), each count write produces reload = {byte, 8'h00} and a `ch_load` pulse.
- R7: With access order 11 (low then high), the first count write is held as the low byte and produces no strobe. The second write is the high byte and produces reload = {second, first} together with `ch_load`.
- R8: A control write that takes effect clears both of that channel's byte toggles and leaves its reload value unchanged.
- R9: `ch_span` equals the reload value when it is non-zero. A reload of zero gives 65536 in binary format and 10000 in BCD format.
- R10: While `sel` and `rd_stb` are high on a count port, `rdata` combinationally shows a byte of that channel's `live_cnt`:
  - the low byte for access order 01;
  - the high byte for access order 10;
  - for access order 11, low then high, with the read toggle advancing on each read edge.
  `rdata` is 0 on the control port and whenever no read is active.
- R11: After reset every channel is in mode 0 with binary format and low-then-high access. The reload value is 0, both toggles are clear and all strobes are low.
- R12: A write happens only when `sel` and `wr_stb` are both high on a rising clock edge. Any other combination changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel | input | 1 | Chip select, active high |
| wr_stb | input | 1 | Write strobe, active high |
| rd_stb | input | 1 | Read strobe, active high |
| addr | input | 2 | Port address (0..2 channel, 3 control) |
| wdata | input | 8 | Write data byte |
| rdata | output | 8 | Read data byte |
| live_cnt | input | 48 | Live counts of the channels, 16 bits each, channel 0 lowest |
| ch_mode | output | 9 | Mode per channel, 3 bits each |
| ch_bcd | output | 3 | BCD flag per channel |
| ch_cfg_wr | output | 3 | Per-channel one-cycle pulse after a control write takes effect |
| ch_load | output | 3 | Per-channel one-cycle pulse when a new reload value is ready |
| ch_reload | output | 48 | Reload value per channel, 16 bits each |
| ch_span | output | 51 | Effective divisor per channel, 17 bits each |

## Verification
The assertions check on every cycle that:
- both strobe vectors are one-hot or zero;
- every strobe is preceded by a matching bus write;
- modes stay in range and change only together with a configuration pulse;
- reload values change only under a load strobe;
- the divisor is never zero and never above 65536;
- `rdata` is quiet outside a count-port read;
- a control byte with access field 00 produces no pulse.

Byte-order assembly, toggle clearing, divisor mapping and readback ordering depend on history across several accesses. Only the bench's scenarios show these, comparing the outputs with a model that tracks each channel's configuration and toggles.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  localparam int BYTE_W = 8;
  localparam int CNT_W  = 2 * BYTE_W;
  localparam int SPAN_W = CNT_W + 1;
  localparam int MODE_W = 3;

  typedef enum logic [1:0] {
    ACC_NONE = 2'b00,
    ACC_LOW  = 2'b01,
    ACC_HIGH = 2'b10,
    ACC_PAIR = 2'b11
  } acc_e;

  typedef struct packed {
    logic [1:0]        target;
    acc_e              acc;
    logic [MODE_W-1:0] mode;
    logic              bcd;
  } ctl_fields_t;

  // Codes 6 and 7 alias onto modes 2 and 3.
  function automatic logic [MODE_W-1:0] fold_mode(input logic [MODE_W-1:0] raw);
    return (raw[2] && raw[1]) ? {1'b0, raw[1:0]} : raw;
  endfunction

  function automatic ctl_fields_t split_ctl(input logic [BYTE_W-1:0] b);
    ctl_fields_t f;
    f.target = b[7:6];
    f.acc    = acc_e'(b[5:4]);
    f.mode   = fold_mode(b[3:1]);
    f.bcd    = b[0];
    return f;
  endfunction

  // Effective divisor: zero reload means the largest count of the format.
  function automatic logic [SPAN_W-1:0] span_of(input logic [CNT_W-1:0] v, input logic bcd);
    if (v != '0) return {1'b0, v};
    return bcd ? SPAN_W'(10000) : SPAN_W'(65536);
  endfunction

endpackage

// File: rtl/tmr_ctl_decode.sv
module tmr_ctl_decode
  import tmr_pkg::*;
#(
  parameter int N_CH = 3
) (
  input  logic              ctl_we,
  input  logic [BYTE_W-1:0] wdata,
  output ctl_fields_t       fields,
  output logic [N_CH-1:0]   cfg_hit
);

  always_comb fields = split_ctl(wdata);

  for (genvar i = 0; i < N_CH; i++) begin : g_hit
    assign cfg_hit[i] = ctl_we && (fields.target == 2'(i)) && (fields.acc != ACC_NONE);
  end

endmodule

// File: rtl/tmr_chan_port.sv
module tmr_chan_port
  import tmr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_hit,
  input  ctl_fields_t       cfg,
  input  logic              cnt_we,
  input  logic              rd_hit,
  input  logic [BYTE_W-1:0] wdata,
  input  logic [CNT_W-1:0]  live,
  output logic [MODE_W-1:0] mode,
  output logic              bcd,
  output logic              cfg_wr,
  output logic              load,
  output logic [CNT_W-1:0]  reload,
  output logic [SPAN_W-1:0] span,
  output logic [BYTE_W-1:0] rbyte
);

  acc_e              acc;
  logic              wtog;
  logic              rtog;
  logic [BYTE_W-1:0] lo_hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode    <= '0;
      bcd     <= 1'b0;
      acc     <= ACC_PAIR;
      wtog    <= 1'b0;
      rtog    <= 1'b0;
      lo_hold <= '0;
      reload  <= '0;
      cfg_wr  <= 1'b0;
      load    <= 1'b0;
    end else begin
      cfg_wr <= cfg_hit;
      load   <= 1'b0;
      if (cfg_hit) begin
        mode <= cfg.mode;
        bcd  <= cfg.bcd;
        acc  <= cfg.acc;
        wtog <= 1'b0;
        rtog <= 1'b0;
      end else begin
        if (cnt_we) begin
          unique case (acc)
            ACC_LOW: begin
              reload <= {{BYTE_W{1'b0}}, wdata};
              load   <= 1'b1;
            end
            ACC_HIGH: begin
              reload <= {wdata, {BYTE_W{1'b0}}};
              load   <= 1'b1;
            end
            ACC_PAIR: begin
              if (!wtog) begin
                lo_hold <= wdata;
                wtog    <= 1'b1;
              end else begin
                reload <= {wdata, lo_hold};
                load   <= 1'b1;
                wtog   <= 1'b0;
              end
            end
            default: ;
          endcase
        end
        if (rd_hit && acc == ACC_PAIR) rtog <= ~rtog;
      end
    end
  end

  always_comb span = span_of(reload, bcd);

  always_comb begin
    unique case (acc)
      ACC_LOW:  rbyte = live[BYTE_W-1:0];
      ACC_HIGH: rbyte = live[CNT_W-1:BYTE_W];
      default:  rbyte = rtog ? live[CNT_W-1:BYTE_W] : live[BYTE_W-1:0];
    endcase
  end

endmodule

// File: rtl/tmr_host_if.sv
module tmr_host_if
  import tmr_pkg::*;
#(
  parameter  int N_CH   = 3,
  localparam int ADDR_W = $clog2(N_CH + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     sel,
  input  logic                     wr_stb,
  input  logic                     rd_stb,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [BYTE_W-1:0]        wdata,
  output logic [BYTE_W-1:0]        rdata,
  input  logic [N_CH*CNT_W-1:0]    live_cnt,
  output logic [N_CH*MODE_W-1:0]   ch_mode,
  output logic [N_CH-1:0]          ch_bcd,
  output logic [N_CH-1:0]          ch_cfg_wr,
  output logic [N_CH-1:0]          ch_load,
  output logic [N_CH*CNT_W-1:0]    ch_reload,
  output logic [N_CH*SPAN_W-1:0]   ch_span
);

  localparam logic [ADDR_W-1:0] CTL_ADDR = ADDR_W'(N_CH);

  // Named bus events, visible to the bound checker.
  logic                         wr_ev;
  logic                         rd_ev;
  logic                         ctl_we;
  logic [N_CH-1:0]              cnt_we;
  logic [N_CH-1:0]              rd_hit;
  logic [N_CH-1:0]              cfg_hit;
  ctl_fields_t                  fields;
  logic [BYTE_W-1:0]            rbyte [N_CH];

  assign wr_ev  = sel && wr_stb;
  assign rd_ev  = sel && rd_stb;
  assign ctl_we = wr_ev && (addr == CTL_ADDR);

  tmr_ctl_decode #(.N_CH(N_CH)) u_dec (
    .ctl_we (ctl_we),
    .wdata  (wdata),
    .fields (fields),
    .cfg_hit(cfg_hit)
  );

  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    assign cnt_we[i] = wr_ev && (addr == ADDR_W'(i));
    assign rd_hit[i] = rd_ev && (addr == ADDR_W'(i));

    tmr_chan_port u_ch (
      .clk    (clk),
      .rst_n  (rst_n),
      .cfg_hit(cfg_hit[i]),
      .cfg    (fields),
      .cnt_we (cnt_we[i]),
      .rd_hit (rd_hit[i]),
      .wdata  (wdata),
      .live   (live_cnt[i*CNT_W +: CNT_W]),
      .mode   (ch_mode[i*MODE_W +: MODE_W]),
      .bcd    (ch_bcd[i]),
      .cfg_wr (ch_cfg_wr[i]),
      .load   (ch_load[i]),
      .reload (ch_reload[i*CNT_W +: CNT_W]),
      .span   (ch_span[i*SPAN_W +: SPAN_W]),
      .rbyte  (rbyte[i])
    );
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < N_CH; i++)
      if (rd_hit[i]) rdata = rbyte[i];
  end

endmodule

// File: rtl/tmr_host_if_chk.sv
module tmr_host_if_chk
  import tmr_pkg::*;
#(
  parameter int N_CH   = 3,
  parameter int ADDR_W = 2
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   sel,
  input logic                   wr_stb,
  input logic                   rd_stb,
  input logic [ADDR_W-1:0]      addr,
  input logic [BYTE_W-1:0]      wdata,
  input logic [BYTE_W-1:0]      rdata,
  input logic [N_CH*MODE_W-1:0] ch_mode,
  input logic [N_CH-1:0]        ch_bcd,
  input logic [N_CH-1:0]        ch_cfg_wr,
  input logic [N_CH-1:0]        ch_load,
  input logic [N_CH*CNT_W-1:0]  ch_reload,
  input logic [N_CH*SPAN_W-1:0] ch_span
);

  localparam logic [ADDR_W-1:0] CTL = ADDR_W'(N_CH);

  assert_load_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ch_load));

  assert_load_cause_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (|ch_load) |-> $past(sel && wr_stb && addr != CTL));

  assert_cfg_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (|ch_cfg_wr) |-> $past(sel && wr_stb && addr == CTL));

  assert_cfg_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ch_cfg_wr));

  assert_cfg_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(|ch_cfg_wr) |-> ($stable(ch_mode) && $stable(ch_bcd)));

  assert_noop_ctl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && wr_stb && addr == CTL && wdata[5:4] == 2'b00) |=> (ch_cfg_wr == '0));

  assert_reload_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(|ch_load) |-> $stable(ch_reload));

  assert_rdata_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!(sel && rd_stb) || addr == CTL) |-> (rdata == '0));

  assert_no_write_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(sel && wr_stb) |=> ((ch_load == '0) && (ch_cfg_wr == '0)));

  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    assert_mode_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ch_mode[i*MODE_W +: MODE_W] <= MODE_W'(5));

    assert_span_bounds_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_span[i*SPAN_W +: SPAN_W] != '0) && (ch_span[i*SPAN_W +: SPAN_W] <= SPAN_W'(65536)));
  end

endmodule

bind tmr_host_if tmr_host_if_chk #(.N_CH(N_CH), .ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .sel      (sel),
  .wr_stb   (wr_stb),
  .rd_stb   (rd_stb),
  .addr     (addr),
  .wdata    (wdata),
  .rdata    (rdata),
  .ch_mode  (ch_mode),
  .ch_bcd   (ch_bcd),
  .ch_cfg_wr(ch_cfg_wr),
  .ch_load  (ch_load),
  .ch_reload(ch_reload),
  .ch_span  (ch_span)
);

// File: tb/tb_tmr_host_if.sv
module tb_tmr_host_if;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel = 1'b0, wr_stb = 1'b0, rd_stb = 1'b0;
  logic [1:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic [47:0] live_cnt = '0;
  logic [8:0]  ch_mode;
  logic [2:0]  ch_bcd, ch_cfg_wr, ch_load;
  logic [47:0] ch_reload;
  logic [50:0] ch_span;

  int vectors = 0, fails = 0;
  bit done = 0;

  // Model state per channel.
  int m_mode[3], m_bcd[3], m_acc[3], m_wtog[3], m_rtog[3], m_lo[3], m_reload[3];

  always #2.5 clk = ~clk;

  tmr_host_if dut (
    .clk(clk), .rst_n(rst_n), .sel(sel), .wr_stb(wr_stb), .rd_stb(rd_stb),
    .addr(addr), .wdata(wdata), .rdata(rdata), .live_cnt(live_cnt),
    .ch_mode(ch_mode), .ch_bcd(ch_bcd), .ch_cfg_wr(ch_cfg_wr), .ch_load(ch_load),
    .ch_reload(ch_reload), .ch_span(ch_span)
  );

  function automatic int exp_mode(int code);
    return (code > 5) ? code - 4 : code;
  endfunction

  function automatic int exp_span(int r, int b);
    if (r != 0) return r;
    return (b != 0) ? 10000 : 65536;
  endfunction

  function automatic string acc_tag(int a);
    case (a)
      1: return "R5";
      2: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic check(string req, int act, int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_state(string tag, int exp_load, int exp_cfg);
    check({"R1 load ", tag}, int'(ch_load), exp_load);
    check({"R2 cfg_wr ", tag}, int'(ch_cfg_wr), exp_cfg);
    for (int i = 0; i < 3; i++) begin
      check({"R3 mode ", tag}, int'(ch_mode[i*3 +: 3]), m_mode[i]);
      check({"R2 bcd ", tag}, int'(ch_bcd[i]), m_bcd[i]);
      check({acc_tag(m_acc[i]), " reload ", tag}, int'(ch_reload[i*16 +: 16]), m_reload[i]);
      check({"R9 span ", tag}, int'(ch_span[i*17 +: 17]), exp_span(m_reload[i], m_bcd[i]));
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 3; i++) begin
      m_mode[i] = 0; m_bcd[i] = 0; m_acc[i] = 3; m_wtog[i] = 0;
      m_rtog[i] = 0; m_lo[i] = 0; m_reload[i] = 0;
    end
  endtask

  // One bus write; selected gates the chip select.
  task automatic bus_write(int a, int d, bit selected, string tag);
    int exp_load = 0, exp_cfg = 0;
    @(negedge clk);
    sel = selected; wr_stb = 1'b1; addr = 2'(a); wdata = 8'(d);
    if (selected) begin
      if (a == 3) begin
        int ch = (d >> 6) & 3, ac = (d >> 4) & 3;
        if (ch != 3 && ac != 0) begin
          m_mode[ch] = exp_mode((d >> 1) & 7); m_bcd[ch] = d & 1; m_acc[ch] = ac;
          m_wtog[ch] = 0; m_rtog[ch] = 0; exp_cfg = 1 << ch;
        end
      end else begin
        case (m_acc[a])
          1: begin m_reload[a] = d; exp_load = 1 << a; end
          2: begin m_reload[a] = d << 8; exp_load = 1 << a; end
          default:
            if (m_wtog[a] == 0) begin m_lo[a] = d; m_wtog[a] = 1; end
            else begin m_reload[a] = (d << 8) | m_lo[a]; m_wtog[a] = 0; exp_load = 1 << a; end
        endcase
      end
    end
    @(negedge clk);
    check_state(tag, exp_load, exp_cfg);
    sel = 1'b0; wr_stb = 1'b0;
  endtask

  task automatic bus_read(int a, string tag);
    int exp;
    @(negedge clk);
    sel = 1'b1; rd_stb = 1'b1; addr = 2'(a);
    #1;
    if (a == 3) exp = 0;
    else begin
      int lv = int'(live_cnt[a*16 +: 16]);
      case (m_acc[a])
        1: exp = lv & 255;
        2: exp = lv >> 8;
        default: begin
          exp = (m_rtog[a] != 0) ? (lv >> 8) : (lv & 255);
          m_rtog[a] = 1 - m_rtog[a];
        end
      endcase
    end
    check({"R10 rdata ", tag}, int'(rdata), exp);
    @(negedge clk);
    sel = 1'b0; rd_stb = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'd2024);
    model_reset();
    repeat (3) @(negedge clk);
    check_state("R11 in reset", 0, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check_state("R11 after reset", 0, 0);

    // R7: reset access order is low then high.
    bus_write(0, 8'h34, 1, "R7 low");
    bus_write(0, 8'h12, 1, "R7 high");
    // R2: 0x54 -> channel 1, mode 2, binary, low only.
    bus_write(3, 8'h54, 1, "R2 0x54");
    check("R2 ch1 mode", int'(ch_mode[5:3]), 2);
    bus_write(1, 8'h00, 1, "R9 zero binary");
    check("R9 ch1 span 65536", int'(ch_span[33:17]), 65536);
    // R3: code 6 aliases to mode 2.
    bus_write(3, 8'h3C, 1, "R3 code6");
    check("R3 ch0 mode", int'(ch_mode[2:0]), 2);
    // R9: BCD zero -> 10000 on channel 2, low only.
    bus_write(3, 8'h91, 1, "R9 bcd cfg");
    bus_write(2, 8'h00, 1, "R9 zero bcd");
    check("R9 ch2 span 10000", int'(ch_span[50:34]), 10000);
    // R6: high only on channel 2.
    bus_write(3, 8'hA7, 1, "R6 cfg");
    bus_write(2, 8'h5A, 1, "R6 write");
    // R4: access 00 and target 11 are ignored.
    bus_write(3, 8'h4A, 1, "R4 acc00");
    bus_write(3, 8'hF6, 1, "R4 target3");
    // R8: a control write mid-pair clears the toggle, reload kept.
    bus_write(3, 8'h30, 1, "R8 cfg0");
    bus_write(0, 8'hAA, 1, "R8 half");
    bus_write(3, 8'h32, 1, "R8 recfg");
    bus_write(0, 8'h11, 1, "R8 low");
    bus_write(0, 8'h22, 1, "R8 high");
    check("R8 ch0 reload", int'(ch_reload[15:0]), 16'h2211);
    // R12: unselected write does nothing.
    bus_write(0, 8'h99, 0, "R12 sel low");
    // R10: reads in low-then-high order, control port.
    live_cnt = 48'h1357_2468_ABCD;
    bus_read(0, "R10 lo");
    bus_read(0, "R10 hi");
    bus_read(3, "R10 ctl");

    for (int n = 0; n < 600; n++) begin
      int op = $urandom_range(0, 99);
      live_cnt = {$urandom(), $urandom()};
      if (op < 20) bus_write(3, $urandom_range(0, 255), 1, "rand ctl");
      else if (op < 65) bus_write($urandom_range(0, 2), $urandom_range(0, 255), 1, "rand cnt");
      else if (op < 90) bus_read($urandom_range(0, 3), "rand rd");
      else bus_write($urandom_range(0, 3), $urandom_range(0, 255), 0, "R12 rand");
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule